// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block is a watchdog counter that advances once per clock of a slow timebase. Software keeps the system alive by writing a fixed 8-bit key to a restart port. The write is honoured only while the refresh window is open. If the counter reaches the end of its period without a valid restart, the block raises a reset request. A misplaced or malformed write also raises a reset request.

Static configuration inputs set three things. The first is the period, which is a power-of-two number of slow-clock ticks. The second is the share of each period during which a restart is accepted. The third is whether an early-warning pulse fires at three quarters of the period. The warning does not stop the counter. A system interrupt handler typically uses it to service the watchdog before the deadline.

The period length is 2^N with N = 7 + `cfg_period`. A "count value seen at an edge" is the counter content that a rising clock edge samples. The first edge after reset, or after any restart, sees count 0.

Top module: `wdt_window`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `warn_irq` and `rst_req` are both low. The count starts from 0.
- R2: With no write, `rst_req` rises in the cycle that follows the edge seeing count 2^N−1, where N = 7 + `cfg_period` (`cfg_period` 0 gives 128 ticks, 1 gives 256).
- R3: `rst_req` is high for a single cycle. The count then restarts from 0, and the window is closed again if the selected mode has a closed part.
- R4: A write of 0xAC while the window is open is a valid restart. The count returns to 0 at that edge and no reset request follows.
- R5: A write of any value other than 0xAC raises `rst_req` in the next cycle, whatever the window state.
- R6: Window encoding of `cfg_win`:
  - 2'b00 opens 50% of the period; the window is closed while the count is below 2^N/2.
  - 2'b01 opens 75%; the window is closed while the count is below 2^N/4.
  - 2'b10 and 2'b11 keep the window always open.
  - A 0xAC write while the window is closed raises `rst_req` in the next cycle.
- R7: With `cfg_warn_en` high, `warn_irq` pulses for one cycle after the edge seeing count 3·2^N/4. It fires at most once per period, and the count keeps running afterwards.
- R8: With `cfg_warn_en` low, `warn_irq` never goes high.
- R9: A valid restart re-arms the warning, so the pulse fires again at three quarters of the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow watchdog timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | 3 | Period select, 2^(7+value) ticks |
| cfg_win | input | 2 | Window open share select |
| cfg_warn_en | input | 1 | Early-warning enable |
| wr_en | input | 1 | Restart port write strobe |
| wr_data | input | 8 | Restart port write value |
| warn_irq | output | 1 | One-cycle early-warning pulse |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Both outputs are registered, so each result is due in the cycle after the edge that causes it:
- a write's verdict appears one cycle after the edge sampling it;
- an overflow appears after the 2^N-th edge of its period;
- the warning appears after edge 3·2^N/4 + 1 of its period.

The driver records the edge at which the current period began. For every edge it drives, it computes the count that the edge sees and pushes any due warning or reset request tagged with that edge number. The monitor samples on falling edges and compares every cycle in which either an event is expected or an output is high. A missing, extra or shifted pulse is therefore caught.

// File: rtl/wdt_window.sv
module wdt_window #(
  parameter int          MIN_EXP = 7,
  parameter logic [7:0]  KEY     = 8'hAC,
  localparam int         CW      = MIN_EXP + 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cfg_period,
  input  logic [1:0] cfg_win,
  input  logic       cfg_warn_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       warn_irq,
  output logic       rst_req
);

  logic [CW-1:0] cnt;
  logic [CW:0]   span, cnt_x;
  logic          warned, closed, at_last, at_warn, good, fault;

  assign span    = (CW+1)'(1) << (MIN_EXP + int'(cfg_period));
  assign cnt_x   = {1'b0, cnt};
  assign at_last = cnt_x == span - 1'b1;
  assign at_warn = cnt_x == span - (span >> 2);

  always_comb begin
    case (cfg_win)
      2'b00:   closed = cnt_x < (span >> 1);
      2'b01:   closed = cnt_x < (span >> 2);
      default: closed = 1'b0;
    endcase
  end

  assign good  = wr_en && (wr_data == KEY) && !closed;
  assign fault = (wr_en && !good) || (at_last && !good);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      warned   <= 1'b0;
      warn_irq <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      rst_req  <= fault;
      warn_irq <= cfg_warn_en && at_warn && !warned && !wr_en;
      if (fault || good) begin
        cnt    <= '0;
        warned <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        if (at_warn) warned <= 1'b1;
      end
    end
  end

endmodule

module wdt_window_chk #(
  parameter int         MIN_EXP = 7,
  parameter logic [7:0] KEY     = 8'hAC,
  localparam int        CW      = MIN_EXP + 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    cfg_period,
  input logic          cfg_warn_en,
  input logic          wr_en,
  input logic [7:0]    wr_data,
  input logic          warn_irq,
  input logic          rst_req,
  input logic [CW-1:0] cnt
);
  logic [CW:0] top;
  assign top = ((CW+1)'(1) << (MIN_EXP + int'(cfg_period))) - 1'b1;

  // R2
  overflow_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt} == top && !wr_en) |=> rst_req);
  // R3
  req_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cnt == '0);
  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !wr_en) |=> !rst_req);
  // R5
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data != KEY) |=> rst_req);
  // R7
  warn_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn_irq |=> !warn_irq);
  // R8
  warn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_warn_en |=> !warn_irq);
endmodule

bind wdt_window wdt_window_chk #(.MIN_EXP(MIN_EXP), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_warn_en(cfg_warn_en),
  .wr_en(wr_en), .wr_data(wr_data), .warn_irq(warn_irq), .rst_req(rst_req), .cnt(cnt)
);

// File: tb/tb_wdt_window.sv
`timescale 1ns/1ps
module tb_wdt_window;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cfg_period = 3'd0;
  logic [1:0] cfg_win = 2'b10;
  logic cfg_warn_en = 1'b1, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic warn_irq, rst_req;

  wdt_window dut (.clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_win(cfg_win),
    .cfg_warn_en(cfg_warn_en), .wr_en(wr_en), .wr_data(wr_data),
    .warn_irq(warn_irq), .rst_req(rst_req));

  always #2 clk = ~clk;

  typedef struct { int cyc; bit w; bit r; string req; } ev_t;
  ev_t q[$];
  int cyc = 0, s = 0, total = 0, fails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit ew, er; string rq;
    ew = 0; er = 0; rq = "R2/R7/R8";
    if (q.size() > 0 && q[0].cyc == cyc) begin
      ew = q[0].w; er = q[0].r; rq = q[0].req; void'(q.pop_front());
    end
    if (ew || er || warn_irq || rst_req) begin
      chk(rq, warn_irq, ew, "warn_irq");
      chk(rq, rst_req, er, "rst_req");
    end
  end

  // one driven edge: caller is at a falling edge
  task automatic step(bit we, logic [7:0] d, string req);
    int e, c, span; bit closed, ok, bad;
    ev_t ev;
    e = cyc + 1; c = e - s - 1; span = 1 << (7 + cfg_period);
    closed = (cfg_win == 2'b00) ? (c < span/2) : (cfg_win == 2'b01) ? (c < span/4) : 1'b0;
    ok = we && d == 8'hAC && !closed;
    bad = we && !ok;
    if (bad || (c == span - 1 && !ok)) begin
      ev.cyc = e; ev.w = 0; ev.r = 1; ev.req = bad ? req : "R2"; q.push_back(ev); s = e;
    end else if (ok) s = e;
    else if (cfg_warn_en && c == span - span/4) begin
      ev.cyc = e; ev.w = 1; ev.r = 0; ev.req = "R7"; q.push_back(ev);
    end
    wr_en = we; wr_data = d;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, "");
  endtask

  task automatic write_at(int c, logic [7:0] d, string req);
    while (cyc - s != c) step(0, 8'h00, "");
    step(1, d, req);
    wr_en = 1'b0;
  endtask

  task automatic restart(logic [2:0] p, logic [1:0] w, logic we);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    cfg_period = p; cfg_win = w; cfg_warn_en = we;
    q.delete();
    repeat (3) @(negedge clk);
    chk("R1", warn_irq, 1'b0, "warn_irq in reset");
    chk("R1", rst_req, 1'b0, "rst_req in reset");
    rst_n = 1'b1; s = cyc;
    @(negedge clk);
    chk("R1", warn_irq, 1'b0, "warn_irq after release");
    chk("R1", rst_req, 1'b0, "rst_req after release");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    // R2 R3 R7: free run, 128-tick period, full window
    restart(3'd0, 2'b10, 1'b1);
    idle(300);
    // R4 R9 R6: 50% window, open refresh then boundary c=63 closed, c=64 open
    restart(3'd0, 2'b00, 1'b1);
    write_at(80, 8'hAC, "R4");
    idle(110);
    write_at(63, 8'hAC, "R6");
    write_at(64, 8'hAC, "R6");
    idle(140);
    // R5: wrong value in open window
    restart(3'd0, 2'b10, 1'b1);
    write_at(50, 8'hAB, "R5");
    write_at(10, 8'h00, "R5");
    idle(20);
    // R6 R8: 75% window, warning off
    restart(3'd0, 2'b01, 1'b0);
    write_at(20, 8'hAC, "R6");
    write_at(31, 8'hAC, "R6");
    write_at(32, 8'hAC, "R6");
    idle(300);
    // R2 R7: 256-tick period, refresh exactly at warning point suppresses it
    restart(3'd1, 2'b00, 1'b1);
    write_at(192, 8'hAC, "R9");
    idle(600);
    @(negedge clk);
    chk("R2", q.size() == 0, 1'b1, "all expected events seen");
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule